// File: doc/BRIEF.md
# Crate Bus Command Decoder

This block sits behind a crate-style backplane slot and turns each strobed command (a 5-bit function code and a subaddress) into a registered response. It reports command acceptance (X), a conditional response (Q), and 24 bits of read data. It keeps an 8-bit control register and an internal expect-header flag. It also emits single-cycle pulses that the neighbouring transmit and receive paths use to pop the output register, push write data, load or extend a header, and clear their buffers.

The response comes one clock after the strobe. Q depends on the command and on the path status flags sampled in the strobe cycle. Commands are not held back: the block takes one command on every clock where the strobe is high. It has no ready signal, and the host paces itself by reading Q. The buffers and the peripheral handshake are outside this block. Only their status flags and control pulses cross its boundary.

Top module: `crate_cmd_decoder`

## Requirements
- R1: A strobed command with subaddress 0 and one of the codes 0, 1, 4, 6, 9, 16, 17, 20, 22, 24, 26, 28, 30 gives x_o=1 one clock after the strobe. Any other code, a nonzero subaddress, or no strobe gives x_o=0 and q_o=0, no pulse, and no change to any state.
- R2: Code 6 returns rdata_o=0x000050 with q_o=1.
- R3: For code 0, q_o = out_rdy & !ctrl[7] & !tmo. When q_o=1, rdata_o carries out_data_i from the strobe cycle and out_pop_o pulses.
- R4: For code 4, q_o = out_rdy & ctrl[7] & !tmo. When q_o=1, rdata_o carries out_data_i and out_pop_o pulses.
- R5: For code 16, q_o = !tmo & !out_rdy & !out_seq & fifo_in_rdy & !expect_header & !ctrl[7]. When q_o=1, data_wr_o pulses and wr_data_o carries the write word.
- R6: For code 22, Q follows the R5 rule without the ctrl[7] term. When q_o=1, hdr_add_o pulses and wr_data_o carries the write word.
- R7: For code 20, q_o = !hdr_pend & !tmo & !out_rdy. When q_o=1, hdr_load_o and fifo_clr_o pulse, wr_data_o carries the write word, ctrl[7] takes write bit 23, and expect-header clears.
- R8: Code 9 sets expect-header and clears ctrl[7], with q_o=1.
- R9: The following codes all give q_o=1. Code 17 loads ctrl[3:0] from write bits 3:0. Codes 24 and 26 clear and set ctrl[5]. Codes 28 and 30 clear and set ctrl[6]. ctrl[4] always reads 0.
- R10: Code 1 returns a status word with q_o=1. The word holds ctrl in bits 23:16 and ext_status_i[7:0] in bits 15:8. Bits 5:0 hold, from bit 0 upward: out_rdy, out_seq, tmo, fifo_in_rdy, hdr_pend, expect-header. Bits 7:6 are 0.
- R11: In reset and after it, x_o, q_o, rdata_o and all pulses are 0, ctrl is 0, and expect-header is 1.
- R12: An accepted command whose Q condition is false gives x_o=1 and q_o=0, rdata_o=0, and no pulse. It changes neither the control register nor expect-header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| func_i | input | 5 | Function code |
| sub_i | input | 4 | Subaddress |
| wdata_i | input | 24 | Write word |
| out_rdy_i | input | 1 | Output register holds data |
| out_seq_i | input | 1 | Output sequence in progress |
| tmo_i | input | 1 | Transfer timeout |
| fifo_in_rdy_i | input | 1 | Transmit buffer can take data |
| hdr_pend_i | input | 1 | Header transfer still pending |
| out_data_i | input | 24 | Output register contents |
| ext_status_i | input | 8 | External static status lines |
| x_o | output | 1 | Command accepted |
| q_o | output | 1 | Conditional response |
| rdata_o | output | 24 | Read data |
| ctrl_o | output | 8 | Control register |
| out_pop_o | output | 1 | Pop output register |
| data_wr_o | output | 1 | Push data word to transmit path |
| hdr_add_o | output | 1 | Push extra header word |
| hdr_load_o | output | 1 | Load header and start transfer |
| fifo_clr_o | output | 1 | Clear both buffers |
| wr_data_o | output | 24 | Word carried with a write pulse |

## Verification
Directed sequences exercise each code in two conditions: one where its Q condition holds and one where it does not. The two reads are tried with ctrl[7] both clear and set, which shows that single and block reads are exclusive. Code 16 and code 22 are issued with ctrl[7] set, which isolates the one term in which their rules differ. A long run follows with random status flags, random codes (listed and unlisted) and occasional nonzero subaddresses. A behavioural model predicts every output on every clock during that run, so a wrong term in any Q rule shows up, as does a side effect from a rejected or unlisted command.

// File: rtl/crate_cmd_pkg.sv
package crate_cmd_pkg;

  localparam int FUNC_W = 5;

  localparam logic [FUNC_W-1:0] FC_RD_ONE  = 5'd0;
  localparam logic [FUNC_W-1:0] FC_STATUS  = 5'd1;
  localparam logic [FUNC_W-1:0] FC_RD_BLK  = 5'd4;
  localparam logic [FUNC_W-1:0] FC_IDENT   = 5'd6;
  localparam logic [FUNC_W-1:0] FC_CLEAR   = 5'd9;
  localparam logic [FUNC_W-1:0] FC_WR_DATA = 5'd16;
  localparam logic [FUNC_W-1:0] FC_CR_LOW  = 5'd17;
  localparam logic [FUNC_W-1:0] FC_HDR     = 5'd20;
  localparam logic [FUNC_W-1:0] FC_HDR_EXT = 5'd22;
  localparam logic [FUNC_W-1:0] FC_EN_OFF  = 5'd24;
  localparam logic [FUNC_W-1:0] FC_EN_ON   = 5'd26;
  localparam logic [FUNC_W-1:0] FC_RUN_OFF = 5'd28;
  localparam logic [FUNC_W-1:0] FC_RUN_ON  = 5'd30;

  typedef enum logic [3:0] {
    OP_NONE, OP_RD_ONE, OP_STATUS, OP_RD_BLK, OP_IDENT, OP_CLEAR,
    OP_WR_DATA, OP_CR_LOW, OP_HDR, OP_HDR_EXT,
    OP_EN_OFF, OP_EN_ON, OP_RUN_OFF, OP_RUN_ON
  } op_e;

  typedef struct packed {
    logic hdr_pend;
    logic fifo_in_rdy;
    logic tmo;
    logic out_seq;
    logic out_rdy;
  } path_flags_t;

  localparam int FLAG_W = $bits(path_flags_t);

endpackage

// File: rtl/crate_cmd_decode.sv
module crate_cmd_decode
  import crate_cmd_pkg::*;
#(
  parameter int SUB_W = 4
) (
  input  logic              cmd_valid,
  input  logic [FUNC_W-1:0] func,
  input  logic [SUB_W-1:0]  sub,
  input  path_flags_t       flags,
  input  logic              cr_hb,
  input  logic              exp_hdr,
  output op_e               op,
  output logic              q_ok
);

  logic wr_path_ok;

  always_comb begin
    op = OP_NONE;
    if (cmd_valid && (sub == '0)) begin
      unique case (func)
        FC_RD_ONE:  op = OP_RD_ONE;
        FC_STATUS:  op = OP_STATUS;
        FC_RD_BLK:  op = OP_RD_BLK;
        FC_IDENT:   op = OP_IDENT;
        FC_CLEAR:   op = OP_CLEAR;
        FC_WR_DATA: op = OP_WR_DATA;
        FC_CR_LOW:  op = OP_CR_LOW;
        FC_HDR:     op = OP_HDR;
        FC_HDR_EXT: op = OP_HDR_EXT;
        FC_EN_OFF:  op = OP_EN_OFF;
        FC_EN_ON:   op = OP_EN_ON;
        FC_RUN_OFF: op = OP_RUN_OFF;
        FC_RUN_ON:  op = OP_RUN_ON;
        default:    op = OP_NONE;
      endcase
    end
  end

  assign wr_path_ok = !flags.tmo && !flags.out_rdy && !flags.out_seq &&
                      flags.fifo_in_rdy && !exp_hdr;

  always_comb begin
    unique case (op)
      OP_NONE:    q_ok = 1'b0;
      OP_RD_ONE:  q_ok = flags.out_rdy && !cr_hb && !flags.tmo;
      OP_RD_BLK:  q_ok = flags.out_rdy && cr_hb && !flags.tmo;
      OP_WR_DATA: q_ok = wr_path_ok && !cr_hb;
      OP_HDR_EXT: q_ok = wr_path_ok;
      OP_HDR:     q_ok = !flags.hdr_pend && !flags.tmo && !flags.out_rdy;
      default:    q_ok = 1'b1;
    endcase
  end

endmodule

// File: rtl/crate_cmd_ctrl.sv
module crate_cmd_ctrl
  import crate_cmd_pkg::*;
#(
  parameter int CR_W = 8,
  parameter int LO_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  op_e             op,
  input  logic            q_ok,
  input  logic [LO_W-1:0] lo_bits,
  input  logic            hdr_msb,
  output logic [CR_W-1:0] cr,
  output logic            exp_hdr
);

  localparam int EN_BIT  = 5;
  localparam int RUN_BIT = 6;
  localparam int HB_BIT  = 7;

  logic [CR_W-1:0] cr_q, cr_d;
  logic            exp_q, exp_d;

  always_comb begin
    cr_d  = cr_q;
    exp_d = exp_q;
    if (q_ok) begin
      unique case (op)
        OP_CLEAR: begin
          cr_d[HB_BIT] = 1'b0;
          exp_d        = 1'b1;
        end
        OP_HDR: begin
          cr_d[HB_BIT] = hdr_msb;
          exp_d        = 1'b0;
        end
        OP_CR_LOW:  cr_d[LO_W-1:0] = lo_bits;
        OP_EN_OFF:  cr_d[EN_BIT]   = 1'b0;
        OP_EN_ON:   cr_d[EN_BIT]   = 1'b1;
        OP_RUN_OFF: cr_d[RUN_BIT]  = 1'b0;
        OP_RUN_ON:  cr_d[RUN_BIT]  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_q  <= '0;
      exp_q <= 1'b1;
    end else begin
      cr_q  <= cr_d;
      exp_q <= exp_d;
    end
  end

  assign cr      = cr_q;
  assign exp_hdr = exp_q;

endmodule

// File: rtl/crate_cmd_resp.sv
module crate_cmd_resp
  import crate_cmd_pkg::*;
#(
  parameter int          DATA_W    = 24,
  parameter int          ES_W      = 8,
  parameter int          CR_W      = 8,
  parameter logic [7:0]  MODULE_ID = 8'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic              q_ok,
  input  path_flags_t       flags,
  input  logic              exp_hdr,
  input  logic [CR_W-1:0]   cr,
  input  logic [ES_W-1:0]   ext_status,
  input  logic [DATA_W-1:0] out_data,
  input  logic [DATA_W-1:0] wdata,
  output logic              x,
  output logic              q,
  output logic [DATA_W-1:0] rdata,
  output logic              out_pop,
  output logic              data_wr,
  output logic              hdr_add,
  output logic              hdr_load,
  output logic              fifo_clr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int LOW_W  = 8;
  localparam int STAT_W = LOW_W + ES_W + CR_W;

  logic [STAT_W-1:0] stat_word;
  logic [DATA_W-1:0] rd_d;
  logic              is_rd, is_wr_pulse;

  assign stat_word = {cr, ext_status, {(LOW_W-FLAG_W-1){1'b0}}, exp_hdr, flags};
  assign is_rd = (op == OP_RD_ONE) || (op == OP_RD_BLK);
  assign is_wr_pulse = q_ok && ((op == OP_WR_DATA) || (op == OP_HDR_EXT) || (op == OP_HDR));

  always_comb begin
    rd_d = '0;
    if (q_ok) begin
      unique case (op)
        OP_RD_ONE, OP_RD_BLK: rd_d = out_data;
        OP_STATUS:            rd_d = DATA_W'(stat_word);
        OP_IDENT:             rd_d = DATA_W'(MODULE_ID);
        default:              rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x        <= 1'b0;
      q        <= 1'b0;
      rdata    <= '0;
      out_pop  <= 1'b0;
      data_wr  <= 1'b0;
      hdr_add  <= 1'b0;
      hdr_load <= 1'b0;
      fifo_clr <= 1'b0;
      wr_data  <= '0;
    end else begin
      x        <= (op != OP_NONE);
      q        <= q_ok;
      rdata    <= rd_d;
      out_pop  <= q_ok && is_rd;
      data_wr  <= q_ok && (op == OP_WR_DATA);
      hdr_add  <= q_ok && (op == OP_HDR_EXT);
      hdr_load <= q_ok && (op == OP_HDR);
      fifo_clr <= q_ok && (op == OP_HDR);
      wr_data  <= is_wr_pulse ? wdata : '0;
    end
  end

endmodule

// File: rtl/crate_cmd_decoder.sv
module crate_cmd_decoder
  import crate_cmd_pkg::*;
#(
  parameter int         DATA_W    = 24,
  parameter int         SUB_W     = 4,
  parameter int         ES_W      = 8,
  parameter int         CR_W      = 8,
  parameter logic [7:0] MODULE_ID = 8'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [4:0]        func_i,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              out_rdy_i,
  input  logic              out_seq_i,
  input  logic              tmo_i,
  input  logic              fifo_in_rdy_i,
  input  logic              hdr_pend_i,
  input  logic [DATA_W-1:0] out_data_i,
  input  logic [ES_W-1:0]   ext_status_i,
  output logic              x_o,
  output logic              q_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CR_W-1:0]   ctrl_o,
  output logic              out_pop_o,
  output logic              data_wr_o,
  output logic              hdr_add_o,
  output logic              hdr_load_o,
  output logic              fifo_clr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam int LO_W   = 4;
  localparam int HB_BIT = 7;
  localparam int MSB_WR = 23;

  path_flags_t     flags;
  op_e             op;
  logic            q_ok;
  logic            exp_hdr;
  logic [CR_W-1:0] cr;

  assign flags = '{hdr_pend:    hdr_pend_i,
                   fifo_in_rdy: fifo_in_rdy_i,
                   tmo:         tmo_i,
                   out_seq:     out_seq_i,
                   out_rdy:     out_rdy_i};

  crate_cmd_decode #(.SUB_W(SUB_W)) u_decode (
    .cmd_valid (cmd_valid_i),
    .func      (func_i),
    .sub       (sub_i),
    .flags     (flags),
    .cr_hb     (cr[HB_BIT]),
    .exp_hdr   (exp_hdr),
    .op        (op),
    .q_ok      (q_ok)
  );

  crate_cmd_ctrl #(.CR_W(CR_W), .LO_W(LO_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .q_ok    (q_ok),
    .lo_bits (wdata_i[LO_W-1:0]),
    .hdr_msb (wdata_i[MSB_WR]),
    .cr      (cr),
    .exp_hdr (exp_hdr)
  );

  crate_cmd_resp #(
    .DATA_W(DATA_W), .ES_W(ES_W), .CR_W(CR_W), .MODULE_ID(MODULE_ID)
  ) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .q_ok       (q_ok),
    .flags      (flags),
    .exp_hdr    (exp_hdr),
    .cr         (cr),
    .ext_status (ext_status_i),
    .out_data   (out_data_i),
    .wdata      (wdata_i),
    .x          (x_o),
    .q          (q_o),
    .rdata      (rdata_o),
    .out_pop    (out_pop_o),
    .data_wr    (data_wr_o),
    .hdr_add    (hdr_add_o),
    .hdr_load   (hdr_load_o),
    .fifo_clr   (fifo_clr_o),
    .wr_data    (wr_data_o)
  );

  assign ctrl_o = cr;

endmodule

// File: rtl/crate_cmd_decoder_chk.sv
module crate_cmd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid_i,
  input logic [4:0]  func_i,
  input logic [3:0]  sub_i,
  input logic        x_o,
  input logic        q_o,
  input logic [23:0] rdata_o,
  input logic [7:0]  ctrl_o,
  input logic        out_pop_o,
  input logic        data_wr_o,
  input logic        hdr_add_o,
  input logic        hdr_load_o,
  input logic        fifo_clr_o
);

  a_r1_q_implies_x: assert property (@(posedge clk) disable iff (!rst_n)
    q_o |-> x_o);

  a_r1_idle_no_x: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_valid_i) |-> (!x_o && !q_o));

  a_r2_ident: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_valid_i) && $past(func_i) == 5'd6 && $past(sub_i) == 4'd0)
    |-> (q_o && rdata_o == 24'h000050));

  a_r12_pulse_needs_q: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pop_o || data_wr_o || hdr_add_o || hdr_load_o) |-> q_o);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_pop_o, data_wr_o, hdr_add_o, hdr_load_o}));

  a_r9_bit4_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_o[4]);

  a_r8_hb_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o[7]) |-> (hdr_load_o || ($past(cmd_valid_i) && $past(func_i) == 5'd9)));

  a_r7_clr_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr_o |-> ($past(func_i) == 5'd20 && q_o));

endmodule

bind crate_cmd_decoder crate_cmd_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid_i (cmd_valid_i),
  .func_i      (func_i),
  .sub_i       (sub_i),
  .x_o         (x_o),
  .q_o         (q_o),
  .rdata_o     (rdata_o),
  .ctrl_o      (ctrl_o),
  .out_pop_o   (out_pop_o),
  .data_wr_o   (data_wr_o),
  .hdr_add_o   (hdr_add_o),
  .hdr_load_o  (hdr_load_o),
  .fifo_clr_o  (fifo_clr_o)
);

// File: tb/crate_cmd_decoder_bench.sv
module crate_cmd_decoder_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, cmd_valid_i, out_rdy_i, out_seq_i, tmo_i, fifo_in_rdy_i, hdr_pend_i;
  logic [4:0]  func_i;
  logic [3:0]  sub_i;
  logic [23:0] wdata_i, out_data_i, rdata_o, wr_data_o;
  logic [7:0]  ext_status_i, ctrl_o;
  logic        x_o, q_o, out_pop_o, data_wr_o, hdr_add_o, hdr_load_o, fifo_clr_o;

  crate_cmd_decoder u_crate_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .func_i(func_i),
    .sub_i(sub_i), .wdata_i(wdata_i), .out_rdy_i(out_rdy_i), .out_seq_i(out_seq_i),
    .tmo_i(tmo_i), .fifo_in_rdy_i(fifo_in_rdy_i), .hdr_pend_i(hdr_pend_i),
    .out_data_i(out_data_i), .ext_status_i(ext_status_i), .x_o(x_o), .q_o(q_o),
    .rdata_o(rdata_o), .ctrl_o(ctrl_o), .out_pop_o(out_pop_o), .data_wr_o(data_wr_o),
    .hdr_add_o(hdr_add_o), .hdr_load_o(hdr_load_o), .fifo_clr_o(fifo_clr_o),
    .wr_data_o(wr_data_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural model state
  logic [7:0]  m_cr = 8'h00;
  logic        m_exph = 1'b1;
  // expected outputs for the next sample
  logic        e_x, e_q;
  logic [23:0] e_rd, e_wd;
  logic [4:0]  e_pulse;  // {pop, wr, add, load, clr}
  string       e_tag;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(e_tag, "x", {31'd0, x_o}, {31'd0, e_x});
    chk(e_tag, "q", {31'd0, q_o}, {31'd0, e_q});
    chk(e_tag, "rdata", {8'd0, rdata_o}, {8'd0, e_rd});
    chk(e_tag, "ctrl", {24'd0, ctrl_o}, {24'd0, m_cr});
    chk(e_tag, "pulses", {27'd0, out_pop_o, data_wr_o, hdr_add_o, hdr_load_o, fifo_clr_o},
        {27'd0, e_pulse});
    chk(e_tag, "wr_data", {8'd0, wr_data_o}, {8'd0, e_wd});
  endtask

  task automatic set_flags(input logic ordy, input logic oseq, input logic tmo,
                           input logic firdy, input logic hpend);
    out_rdy_i = ordy; out_seq_i = oseq; tmo_i = tmo;
    fifo_in_rdy_i = firdy; hdr_pend_i = hpend;
  endtask

  task automatic drive(input logic v, input int f, input int s, input logic [23:0] w);
    logic wok;
    cmd_valid_i = v; func_i = 5'(f); sub_i = 4'(s); wdata_i = w;
    e_x = 1'b0; e_q = 1'b0; e_rd = '0; e_wd = '0; e_pulse = '0; e_tag = "R1";
    wok = !tmo_i && !out_rdy_i && !out_seq_i && fifo_in_rdy_i && !m_exph;
    if (v && s == 0) begin
      case (f)
        0: begin e_x = 1; e_tag = "R3"; e_q = out_rdy_i && !m_cr[7] && !tmo_i;
             if (e_q) begin e_rd = out_data_i; e_pulse = 5'b10000; end end
        4: begin e_x = 1; e_tag = "R4"; e_q = out_rdy_i && m_cr[7] && !tmo_i;
             if (e_q) begin e_rd = out_data_i; e_pulse = 5'b10000; end end
        1: begin e_x = 1; e_q = 1; e_tag = "R10";
             e_rd = {m_cr, ext_status_i, 2'b00, m_exph, hdr_pend_i, fifo_in_rdy_i,
                     tmo_i, out_seq_i, out_rdy_i}; end
        6: begin e_x = 1; e_q = 1; e_tag = "R2"; e_rd = 24'h000050; end
        9: begin e_x = 1; e_q = 1; e_tag = "R8"; m_cr[7] = 1'b0; m_exph = 1'b1; end
        16: begin e_x = 1; e_tag = "R5"; e_q = wok && !m_cr[7];
              if (e_q) begin e_pulse = 5'b01000; e_wd = w; end end
        22: begin e_x = 1; e_tag = "R6"; e_q = wok;
              if (e_q) begin e_pulse = 5'b00100; e_wd = w; end end
        20: begin e_x = 1; e_tag = "R7"; e_q = !hdr_pend_i && !tmo_i && !out_rdy_i;
              if (e_q) begin e_pulse = 5'b00011; e_wd = w; m_cr[7] = w[23]; m_exph = 1'b0; end end
        17: begin e_x = 1; e_q = 1; e_tag = "R9"; m_cr[3:0] = w[3:0]; end
        24: begin e_x = 1; e_q = 1; e_tag = "R9"; m_cr[5] = 1'b0; end
        26: begin e_x = 1; e_q = 1; e_tag = "R9"; m_cr[5] = 1'b1; end
        28: begin e_x = 1; e_q = 1; e_tag = "R9"; m_cr[6] = 1'b0; end
        30: begin e_x = 1; e_q = 1; e_tag = "R9"; m_cr[6] = 1'b1; end
        default: ;
      endcase
    end
    if (e_x && !e_q) e_tag = "R12";
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int codes[13] = '{0, 1, 4, 6, 9, 16, 17, 20, 22, 24, 26, 28, 30};

  initial begin
    rst_n = 1'b0; cmd_valid_i = 0; func_i = 0; sub_i = 0; wdata_i = 0;
    out_data_i = 24'hABCDEF; ext_status_i = 8'h5A;
    set_flags(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R11: reset state
    e_x = 0; e_q = 0; e_rd = 0; e_wd = 0; e_pulse = 0; e_tag = "R11";
    compare_all();
    rst_n = 1'b1;
    // R11/R10: expect-header is 1 after reset
    drive(1, 1, 0, 0);
    // R12: data write refused while header expected, state kept
    set_flags(0, 0, 0, 1, 0);
    drive(1, 16, 0, 24'h111111);
    drive(1, 1, 0, 0);
    // R7: header with MSB set sets ctrl[7]
    set_flags(0, 0, 0, 1, 0);
    drive(1, 20, 0, 24'h812345);
    // R4 / R3 with ctrl[7] set
    set_flags(1, 0, 0, 0, 0); out_data_i = 24'h0F0F0F;
    drive(1, 4, 0, 0);
    drive(1, 0, 0, 0);
    // R5 refused by ctrl[7], R6 accepted
    set_flags(0, 0, 0, 1, 0);
    drive(1, 16, 0, 24'h222222);
    drive(1, 22, 0, 24'h333333);
    // R7 refused by pending header, then accepted with MSB clear
    set_flags(0, 0, 0, 1, 1);
    drive(1, 20, 0, 24'h7FFFFF);
    set_flags(0, 0, 0, 1, 0);
    drive(1, 20, 0, 24'h123456);
    drive(1, 16, 0, 24'h444444);
    set_flags(1, 0, 0, 0, 0);
    drive(1, 0, 0, 0);
    drive(1, 4, 0, 0);
    // R9: control bits
    drive(1, 17, 0, 24'hFFFFFA);
    drive(1, 26, 0, 0);
    drive(1, 30, 0, 0);
    drive(1, 1, 0, 0);
    drive(1, 24, 0, 0);
    drive(1, 28, 0, 0);
    // R2, R8, R1
    drive(1, 6, 0, 0);
    drive(1, 9, 0, 0);
    drive(1, 1, 0, 0);
    drive(1, 3, 0, 24'hFFFFFF);
    drive(1, 6, 2, 0);
    drive(1, 26, 1, 0);
    drive(0, 26, 0, 0);
    drive(1, 1, 0, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int f;
      set_flags(1'($urandom), 1'(($urandom % 4) == 0), 1'(($urandom % 4) == 0),
                1'(($urandom % 4) != 0), 1'($urandom));
      out_data_i = 24'($urandom);
      ext_status_i = 8'($urandom);
      f = (($urandom % 5) == 0) ? int'($urandom % 32) : codes[$urandom % 13];
      drive(1'(($urandom % 4) != 0), f, (($urandom % 8) == 0) ? 1 : 0, 24'($urandom));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule